// File: doc/BRIEF.md
# Selectable Decade Frequency Divider

The block divides an input clock by 10, 100, 1,000 or 10,000 and presents the result as a square wave with a 50% duty cycle. Four identical decade stages are cascaded. All of them run from the falling edge of the input clock and are gated by synchronous enables, so no stage is clocked by another stage's output. Inside each decade, a five-state counter drives a toggle flop that acts as a divide-by-two. Because the toggle flop forms the tap, every tap is high for exactly half its period.

A two-bit select code chooses which tap drives the output. The code is inverted with respect to depth: code 00 picks the deepest tap and code 11 the shallowest. The select lines feed the output multiplexer directly. A change of select takes effect at the next transition of the newly chosen tap and leaves every counter running. An active-high asynchronous reset clears all decades and holds the output low.

Each decade is a small state machine with states QUIN_0, QUIN_1, QUIN_2, QUIN_3 and QUIN_4. On an enabled falling edge, the transition ADVANCE moves the state to the next count. The transition WRAP takes QUIN_4 back to QUIN_0 and toggles the decade's tap flop. A decade passes its enable on to the next decade only when it wraps while its tap is high, which is the falling edge of its tap.

Top module: `decade_divider_top`

## Requirements
- R1: The output changes only as a result of a falling edge of `clk_in`; a rising edge never changes it.
- R2: While `rst_hi` is high, the output is low and every decade is cleared to QUIN_0 with its tap low. The reset acts without waiting for a clock edge.
- R3: Select code {sel_hi, sel_lo} = 11 divides by 10: the output is high for 5 and low for 5 falling edges.
- R4: Select code 10 divides by 100: the output is high for 50 and low for 50 falling edges.
- R5: Select code 01 divides by 1,000: the output is high for 500 and low for 500 falling edges.
- R6: Select code 00 divides by 10,000: the output is high for 5,000 and low for 5,000 falling edges.
- R7: After reset is released, the first output rising edge follows the N/2-th falling edge of `clk_in`, where N is the selected division.
- R8: A change of select resets no counter. For example, after 30 falling edges under code 11, switching to code 10 gives a first rising edge 20 falling edges later.
- R9: The tap of each decade after the first toggles only on a falling edge where the tap of the decade before it falls.
- R10: Within a decade, the tap toggles only on the WRAP transition from QUIN_4 to QUIN_0.
- R11: A decade whose enable is low keeps its state across the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock; the decades advance on its falling edge |
| rst_hi | input | 1 | Asynchronous active-high clear |
| sel_lo | input | 1 | Low bit of the division select code |
| sel_hi | input | 1 | High bit of the division select code |
| div_out | output | 1 | Divided square-wave output |

## Verification
The assertions check, on every falling edge, the internal mechanics that hold for any select code. They confirm that decade states stay put without an enable, that a tap toggles only on the WRAP from QUIN_4, that each tap toggles only when the tap before it falls, and that the output stays low during reset. Some behaviours can be shown only by the bench's scenarios, because they depend on absolute counts and on the mapping of select codes to taps. These are the high and low times for each code, the delay to the first rising edge after reset, the immunity of the output to rising edges, and the effect of a select change in the middle of a run.

// File: rtl/decdiv_pkg.sv
package decdiv_pkg;
    // Five counts of the quinary part of one decade
    typedef enum logic [2:0] {
        QUIN_0 = 3'd0,
        QUIN_1 = 3'd1,
        QUIN_2 = 3'd2,
        QUIN_3 = 3'd3,
        QUIN_4 = 3'd4
    } quin_state_t;

    localparam int SEL_BITS = 2;
endpackage

// File: rtl/decade_stage.sv
module decade_stage
    import decdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv_en,
    output logic tap_q,
    output logic carry_out
);
    quin_state_t state_q, state_d;
    logic        wrap_now;

    // Next-state logic: ADVANCE through the counts, WRAP from QUIN_4
    always_comb begin
        state_d = state_q;
        if (adv_en) begin
            unique case (state_q)
                QUIN_0:  state_d = QUIN_1;
                QUIN_1:  state_d = QUIN_2;
                QUIN_2:  state_d = QUIN_3;
                QUIN_3:  state_d = QUIN_4;
                QUIN_4:  state_d = QUIN_0;
                default: state_d = QUIN_0;
            endcase
        end
    end

    // State register, falling edge, asynchronous clear
    always_ff @(negedge clk or posedge rst) begin
        if (rst) state_q <= QUIN_0;
        else     state_q <= state_d;
    end

    // Output process: toggle flop and carry to the next decade
    always_comb begin
        wrap_now  = adv_en && (state_q == QUIN_4);
        carry_out = wrap_now && tap_q;
    end

    always_ff @(negedge clk or posedge rst) begin
        if (rst)           tap_q <= 1'b0;
        else if (wrap_now) tap_q <= ~tap_q;
    end

    assert_hold_when_idle_R11: assert property (@(negedge clk) disable iff (rst)
        !adv_en |=> $stable(state_q));

    assert_toggle_on_wrap_R10: assert property (@(negedge clk) disable iff (rst)
        !$stable(tap_q) |-> ($past(state_q) == QUIN_4 && state_q == QUIN_0));
endmodule

// File: rtl/tap_selector.sv
module tap_selector #(
    parameter int NUM_TAPS = 4,
    parameter int SEL_W    = 2
) (
    input  logic [NUM_TAPS-1:0] taps,
    input  logic [SEL_W-1:0]    sel,
    output logic                tap_out
);
    // Highest code picks the shallowest tap, code zero the deepest
    always_comb begin
        tap_out = 1'b0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            if (sel == SEL_W'(NUM_TAPS - 1 - i)) tap_out = taps[i];
        end
    end
endmodule

// File: rtl/decade_divider_top.sv
module decade_divider_top
    import decdiv_pkg::*;
#(
    parameter int NUM_STAGES = 4
) (
    input  logic clk_in,
    input  logic rst_hi,
    input  logic sel_lo,
    input  logic sel_hi,
    output logic div_out
);
    logic [NUM_STAGES-1:0] tap;
    logic [NUM_STAGES:0]   en_chain;
    logic [SEL_BITS-1:0]   sel_code;

    assign en_chain[0] = 1'b1;
    assign sel_code    = {sel_hi, sel_lo};

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_decade
        decade_stage u_stage (
            .clk       (clk_in),
            .rst       (rst_hi),
            .adv_en    (en_chain[k]),
            .tap_q     (tap[k]),
            .carry_out (en_chain[k+1])
        );
        if (k > 0) begin : g_cascade_chk
            assert_cascade_R9: assert property (@(negedge clk_in) disable iff (rst_hi)
                !$stable(tap[k]) |-> $fell(tap[k-1]));
        end
    end

    tap_selector #(
        .NUM_TAPS (NUM_STAGES),
        .SEL_W    (SEL_BITS)
    ) u_sel (
        .taps    (tap),
        .sel     (sel_code),
        .tap_out (div_out)
    );

    always @(negedge clk_in) begin
        if (rst_hi) assert_out_low_in_reset_R2: assert (div_out == 1'b0);
    end
endmodule

// File: tb/decade_divider_top_bench.sv
module decade_divider_top_bench;
    logic       clk_in = 1'b0;
    logic       rst_hi = 1'b1;
    logic [1:0] sel    = 2'b11;
    logic       div_out;
    int         n_checks = 0;
    int         n_fails  = 0;

    always #2.5 clk_in = ~clk_in;

    decade_divider_top u_decade_divider_top (
        .clk_in  (clk_in),
        .rst_hi  (rst_hi),
        .sel_lo  (sel[0]),
        .sel_hi  (sel[1]),
        .div_out (div_out)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] code);
        @(posedge clk_in); #1;
        rst_hi = 1'b1;
        sel    = code;
        repeat (3) @(posedge clk_in);
        #1 rst_hi = 1'b0;
    endtask

    // Count falling edges (seen at the following rising edge) until the output reaches lvl
    task automatic count_until(input logic lvl, input int limit, output int cnt);
        cnt = 0;
        while (cnt < limit) begin
            @(posedge clk_in); #1;
            cnt++;
            if (div_out == lvl) break;
        end
    endtask

    task automatic test_reset_hold();
        @(posedge clk_in); #1 rst_hi = 1'b1;
        for (int c = 0; c < 4; c++) begin
            sel = 2'(c);
            repeat (12) @(posedge clk_in);
            #1 check_eq("R2 output low in reset", int'(div_out), 0);
        end
        // asynchronous clear in the middle of a run
        do_reset(2'b11);
        repeat (7) @(posedge clk_in);
        #1 check_eq("R3 output high before async reset", int'(div_out), 1);
        #1 rst_hi = 1'b1;
        #0.5 check_eq("R2 async clear without clock edge", int'(div_out), 0);
    endtask

    task automatic test_division(input logic [1:0] code, input int n, input string req);
        int cnt;
        do_reset(code);
        count_until(1'b1, n, cnt);
        check_eq({req, " R7 first rise after reset"}, cnt, n / 2);
        count_until(1'b0, n, cnt);
        check_eq({req, " high time"}, cnt, n / 2);
        count_until(1'b1, n, cnt);
        check_eq({req, " low time"}, cnt, n / 2);
    endtask

    task automatic test_rise_immunity();
        logic before_rise;
        do_reset(2'b11);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_in); #1 before_rise = div_out;
            @(posedge clk_in); #1;
            check_eq("R1 no change on rising edge", int'(div_out), int'(before_rise));
        end
    endtask

    task automatic test_select_change();
        int cnt;
        do_reset(2'b11);
        repeat (30) @(posedge clk_in);
        #1 check_eq("R3 low after 30 falls", int'(div_out), 0);
        sel = 2'b10;
        #0.5 check_eq("R8 tap1 low at switch", int'(div_out), 0);
        count_until(1'b1, 200, cnt);
        check_eq("R8 R9 rise 20 falls after switch", cnt, 20);
    endtask

    initial begin
        test_reset_hold();
        test_rise_immunity();
        test_division(2'b11, 10,    "R3 R10");
        test_division(2'b10, 100,   "R4 R9");
        test_division(2'b01, 1000,  "R5 R11");
        test_division(2'b00, 10000, "R6");
        test_select_change();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk_in);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule